// File: doc/BRIEF.md
# Burst DMA Channel Engine

This block is one DMA channel. It copies bytes between a wide memory space and a small window of peripheral registers. The wide side uses a 24-bit address made of an 8-bit bank and a 16-bit offset. The narrow side uses an 8-bit register number inside a window that the system decodes at 0x2100-0x21FF. Software loads the channel configuration:

- the direction of the copy;
- a 3-bit pattern code;
- the base peripheral register;
- the bank and the 16-bit offset;
- a byte count;
- two step flags.

Software then sets the enable bit and pulses start. The channel first spends a fixed setup period. It then moves one byte per slot, and each slot has a read half and a write half.

For each byte, the peripheral register number is the base register plus an offset. The pattern code picks how that offset follows a 2-bit byte index. Some wide-side regions hold system registers, and the channel never touches them. A copy between work RAM and the peripheral port that leads back into work RAM is suppressed.

The burst ends in one of two ways. It ends when the count runs out, and the channel then clears its own enable. It also ends when software clears the enable, and the byte in flight still completes.

Top module: `bdma_channel`

## Requirements
- R1: After reset `busy` and `en` are low and no strobe is asserted.
- R2: A `start` pulse while the enable bit is set begins a burst, and `busy` goes high on the next cycle. A `start` pulse while the enable bit is clear is ignored: `busy` stays low and no strobe appears.
- R3: The peripheral register for a byte is `breg` plus an offset taken from the 2-bit byte index. The index starts at 0 and wraps modulo 4.
  - Codes 1 and 5 add index bit 0.
  - Codes 3 and 7 add index bit 1.
  - Code 4 adds the whole index.
  - Codes 0, 2 and 6 add 0.
- R4: In banks whose bit 6 is clear (00-3F, 80-BF), these wide-side offsets are blocked: 2100-21FF, 4000-41FF, 4200-421F and 4300-437F. A blocked read raises no strobe and yields 0x00. A blocked write raises no strobe.
- R5: A byte is a loop when the peripheral register is 0x80 and the wide address is work RAM. Work RAM is bank 7E or 7F, or offsets 0000-1FFF in banks whose bit 6 is clear. For a loop byte the peripheral read raises no strobe and yields 0x00, and the peripheral write raises no strobe.
- R6: With `dir`=0 the channel reads the wide side and writes the peripheral side. With `dir`=1 it reads the peripheral side and writes the wide side.
- R7: After each byte the 16-bit offset steps, wrapping at 16 bits, and the bank never changes.
  - With `fixed`=1 the offset holds, whatever `reverse` is.
  - Otherwise it goes down by 1 when `reverse`=1 and up by 1 when `reverse`=0.
- R8: The count drops by one per byte, and the burst ends after the byte that brings it to zero. A count of 0 means 65536 bytes.
- R9: A burst of N bytes keeps `busy` high for 8+8N cycles.
  - The first 8 cycles are setup.
  - In each 8-cycle byte slot, the read strobe is high for the first 4 cycles and the data is taken in the 4th.
  - The write strobe is high for one cycle, the 5th, and carries that data on `wdata`.
- R10: When a burst completes, the enable bit clears in the same cycle that `busy` falls. If software clears the enable during a burst, the burst stops after the byte in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| start | input | 1 | Burst start pulse |
| dir | input | 1 | 0: wide to peripheral, 1: peripheral to wide |
| mode | input | 3 | Register pattern code |
| breg | input | 8 | Base peripheral register |
| bank | input | 8 | Wide-side bank |
| src | input | 16 | Starting wide-side offset |
| count | input | 16 | Byte count, 0 means 65536 |
| fixed | input | 1 | Hold the offset |
| reverse | input | 1 | Step the offset downward |
| en_o | output | 1 | Current enable bit |
| busy_o | output | 1 | Burst in progress |
| a_addr_o | output | 24 | Wide-side address |
| a_rd_o | output | 1 | Wide-side read strobe |
| a_wr_o | output | 1 | Wide-side write strobe |
| a_rdata_i | input | 8 | Wide-side read data |
| b_addr_o | output | 8 | Peripheral register number |
| b_rd_o | output | 1 | Peripheral read strobe |
| b_wr_o | output | 1 | Peripheral write strobe |
| b_rdata_i | input | 8 | Peripheral read data |
| wdata_o | output | 8 | Write data for either side |

## Verification
The assertions rely on a few properties of the bus model. It answers a read combinationally and holds the data while the read strobe is high. Reset is applied before the first edge. The configuration inputs only need to be valid in the cycle that `start` is taken, because they are latched then.

The bench drives every input on the falling edge. It changes the configuration only while the channel is idle. Its bus model forms read data from the address alone, so a dropped or zero-substituted byte shows up as a wrong or missing write on the scoreboard.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
    parameter int unsigned BANK_W   = 8;
    parameter int unsigned OFF_W    = 16;
    parameter int unsigned DATA_W   = 8;
    parameter int unsigned MODE_W   = 3;
    parameter int unsigned IDX_W    = 2;
    parameter int unsigned OVH_CYC  = 8;
    parameter int unsigned HALF_CYC = 4;
    localparam int unsigned SLOT_CYC = 2 * HALF_CYC;
    localparam int unsigned TICK_W   = $clog2((OVH_CYC > SLOT_CYC) ? OVH_CYC : SLOT_CYC);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OVH  = 2'd1,
        ST_XFER = 2'd2
    } st_e;

    typedef struct packed {
        st_e               st;
        logic              en;
        logic [TICK_W-1:0] tick;
        logic [IDX_W-1:0]  idx;
        logic [OFF_W-1:0]  off;
        logic [OFF_W-1:0]  cnt;
        logic [DATA_W-1:0] data;
        logic              dir;
        logic [MODE_W-1:0] mode;
        logic [7:0]        breg;
        logic [BANK_W-1:0] bank;
        logic              fixed;
        logic              rev;
    } chan_t;
endpackage

// File: rtl/bdma_region_chk.sv
module bdma_region_chk (
    input  logic [7:0]  bank,
    input  logic [10:0] off_hi,
    output logic        a_ok,
    output logic        is_wram
);
    logic sys_bank;
    logic hit;

    always_comb begin
        sys_bank = ~bank[6];
        hit = (off_hi[10:3] == 8'h21)
            | (off_hi[10:4] == 7'h20)
            | (off_hi == 11'h210)
            | (off_hi[10:2] == 9'h086);
        a_ok    = ~(sys_bank & hit);
        is_wram = (bank == 8'h7E) | (bank == 8'h7F) | (sys_bank & (off_hi[10:8] == 3'b000));
    end
endmodule

// File: rtl/bdma_breg_step.sv
module bdma_breg_step #(
    parameter int unsigned MODE_W = 3,
    parameter int unsigned IDX_W  = 2
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [IDX_W-1:0]  idx,
    input  logic [7:0]        breg,
    output logic [7:0]        b_addr
);
    logic [7:0] step;

    always_comb begin
        case (mode)
            3'd1, 3'd5: step = {7'd0, idx[0]};
            3'd3, 3'd7: step = {7'd0, idx[1]};
            3'd4:       step = {{(8-IDX_W){1'b0}}, idx};
            default:    step = 8'd0;
        endcase
        b_addr = breg + step;
    end
endmodule

// File: rtl/bdma_channel.sv
module bdma_channel
    import bdma_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en_wr,
    input  logic                      en_wdata,
    input  logic                      start,
    input  logic                      dir,
    input  logic [MODE_W-1:0]         mode,
    input  logic [7:0]                breg,
    input  logic [BANK_W-1:0]         bank,
    input  logic [OFF_W-1:0]          src,
    input  logic [OFF_W-1:0]          count,
    input  logic                      fixed,
    input  logic                      reverse,
    output logic                      en_o,
    output logic                      busy_o,
    output logic [BANK_W+OFF_W-1:0]   a_addr_o,
    output logic                      a_rd_o,
    output logic                      a_wr_o,
    input  logic [DATA_W-1:0]         a_rdata_i,
    output logic [7:0]                b_addr_o,
    output logic                      b_rd_o,
    output logic                      b_wr_o,
    input  logic [DATA_W-1:0]         b_rdata_i,
    output logic [DATA_W-1:0]         wdata_o
);
    localparam logic [TICK_W-1:0] OVH_LAST  = TICK_W'(OVH_CYC - 1);
    localparam logic [TICK_W-1:0] RD_LAST   = TICK_W'(HALF_CYC - 1);
    localparam logic [TICK_W-1:0] WR_TICK   = TICK_W'(HALF_CYC);
    localparam logic [TICK_W-1:0] SLOT_LAST = TICK_W'(SLOT_CYC - 1);
    localparam logic [OFF_W-1:0]  CNT_ONE   = OFF_W'(1);

    chan_t      s_d, s_q;
    logic       a_ok, is_wram, loop_ok;
    logic [7:0] b_addr;
    logic       rd_half, wr_slot, a_rd_d, a_wr_d, b_rd_d, b_wr_d;

    bdma_region_chk u_region (
        .bank    (s_q.bank),
        .off_hi  (s_q.off[OFF_W-1:OFF_W-11]),
        .a_ok    (a_ok),
        .is_wram (is_wram)
    );

    bdma_breg_step #(.MODE_W(MODE_W), .IDX_W(IDX_W)) u_step (
        .mode   (s_q.mode),
        .idx    (s_q.idx),
        .breg   (s_q.breg),
        .b_addr (b_addr)
    );

    assign loop_ok = ~((b_addr == 8'h80) & is_wram);

    always_comb begin
        s_d = s_q;
        if (en_wr) s_d.en = en_wdata;
        rd_half = (s_q.st == ST_XFER) && (s_q.tick < WR_TICK);
        wr_slot = (s_q.st == ST_XFER) && (s_q.tick == WR_TICK);
        a_rd_d  = rd_half & ~s_q.dir & a_ok;
        b_rd_d  = rd_half &  s_q.dir & loop_ok;
        b_wr_d  = wr_slot & ~s_q.dir & loop_ok;
        a_wr_d  = wr_slot &  s_q.dir & a_ok;
        case (s_q.st)
            ST_IDLE: begin
                if (start && s_q.en) begin
                    s_d.st    = ST_OVH;
                    s_d.tick  = '0;
                    s_d.idx   = '0;
                    s_d.dir   = dir;
                    s_d.mode  = mode;
                    s_d.breg  = breg;
                    s_d.bank  = bank;
                    s_d.off   = src;
                    s_d.cnt   = count;
                    s_d.fixed = fixed;
                    s_d.rev   = reverse;
                end
            end
            ST_OVH: begin
                s_d.tick = s_q.tick + 1'b1;
                if (s_q.tick == OVH_LAST) begin
                    s_d.st   = ST_XFER;
                    s_d.tick = '0;
                end
            end
            ST_XFER: begin
                s_d.tick = s_q.tick + 1'b1;
                if (s_q.tick == RD_LAST) begin
                    if (s_q.dir) s_d.data = loop_ok ? b_rdata_i : '0;
                    else         s_d.data = a_ok ? a_rdata_i : '0;
                end
                if (s_q.tick == SLOT_LAST) begin
                    s_d.tick = '0;
                    s_d.idx  = s_q.idx + 1'b1;
                    s_d.cnt  = s_q.cnt - 1'b1;
                    if (!s_q.fixed) s_d.off = s_q.rev ? s_q.off - 1'b1 : s_q.off + 1'b1;
                    if (s_q.cnt == CNT_ONE || !s_q.en) begin
                        s_d.st = ST_IDLE;
                        s_d.en = 1'b0;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en_o     = s_q.en;
    assign busy_o   = (s_q.st != ST_IDLE);
    assign a_addr_o = {s_q.bank, s_q.off};
    assign b_addr_o = b_addr;
    assign a_rd_o   = a_rd_d;
    assign a_wr_o   = a_wr_d;
    assign b_rd_o   = b_rd_d;
    assign b_wr_o   = b_wr_d;
    assign wdata_o  = s_q.data;

    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(a_rd_o || a_wr_o || b_rd_o || b_wr_o));
    p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(a_addr_o[23:16]));
    p_reg_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_rd_o || a_wr_o) && !a_addr_o[22]) |-> (a_addr_o[15:8] != 8'h21));
    p_no_wram_loop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((b_rd_o || b_wr_o) && b_addr_o == 8'h80) |->
        (a_addr_o[23:17] != 7'h3F) && !(!a_addr_o[22] && a_addr_o[15:13] == 3'b000));
    p_one_side_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_wr_o && b_wr_o) && !(a_rd_o && b_rd_o) && !(a_rd_o && a_wr_o) && !(b_rd_o && b_wr_o));
    p_write_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr_o || b_wr_o) |=> !(a_wr_o || b_wr_o));
    p_selfclear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !en_o);
endmodule

// File: tb/bdma_channel_bench.sv
module bdma_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_wr = 1'b0, en_wdata = 1'b0, start = 1'b0, dir = 1'b0;
    logic [2:0]  mode = '0;
    logic [7:0]  breg = '0, bank = '0;
    logic [15:0] src = '0, count = '0;
    logic        fixed = 1'b0, reverse = 1'b0;
    logic        en_o, busy_o, a_rd_o, a_wr_o, b_rd_o, b_wr_o;
    logic [23:0] a_addr_o;
    logic [7:0]  b_addr_o, wdata_o, a_rdata_i, b_rdata_i;

    int total = 0;
    int bad = 0;
    logic [32:0] expq[$];

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_a(logic [23:0] ad);
        return ad[7:0] ^ ad[15:8] ^ ad[23:16] ^ 8'h5A;
    endfunction
    function automatic logic [7:0] mem_b(logic [7:0] r);
        return ~r ^ 8'h3C;
    endfunction

    assign a_rdata_i = mem_a(a_addr_o);
    assign b_rdata_i = mem_b(b_addr_o);

    bdma_channel u_bdma_channel (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata), .start(start),
        .dir(dir), .mode(mode), .breg(breg), .bank(bank), .src(src), .count(count),
        .fixed(fixed), .reverse(reverse), .en_o(en_o), .busy_o(busy_o),
        .a_addr_o(a_addr_o), .a_rd_o(a_rd_o), .a_wr_o(a_wr_o), .a_rdata_i(a_rdata_i),
        .b_addr_o(b_addr_o), .b_rd_o(b_rd_o), .b_wr_o(b_wr_o), .b_rdata_i(b_rdata_i),
        .wdata_o(wdata_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference rules, written from the requirements
    function automatic bit m_aok(logic [23:0] ad);
        logic [15:0] o = ad[15:0];
        if (ad[22]) return 1'b1;
        if (o[15:8] == 8'h21 || o[15:9] == 7'h20 || o[15:5] == 11'h210 || o[15:7] == 9'h086)
            return 1'b0;
        return 1'b1;
    endfunction
    function automatic bit m_wram(logic [23:0] ad);
        return (ad[23:16] == 8'h7E) || (ad[23:16] == 8'h7F) || (!ad[22] && ad[15:0] < 16'h2000);
    endfunction
    function automatic logic [7:0] m_breg(logic [2:0] md, logic [1:0] ix, logic [7:0] base);
        case (md)
            3'd1, 3'd5: return base + {7'd0, ix[0]};
            3'd3, 3'd7: return base + {7'd0, ix[1]};
            3'd4:       return base + {6'd0, ix};
            default:    return base;
        endcase
    endfunction

    // monitor: pops one expected write per observed write strobe
    always @(negedge clk) begin
        if (rst_n && (a_wr_o || b_wr_o)) begin
            logic [32:0] got;
            got = a_wr_o ? {1'b1, a_addr_o, wdata_o} : {1'b0, 16'h0, b_addr_o, wdata_o};
            if (expq.size() == 0) chk(1'b0, "R6", "unexpected write", longint'(got), 0);
            else begin
                logic [32:0] e;
                e = expq.pop_front();
                chk(got == e, "R3/R6/R7", "write side/addr/data", longint'(got), longint'(e));
            end
        end
    end

    task automatic run(input logic d, input logic [2:0] md, input logic [7:0] br,
                       input logic [7:0] bk, input logic [15:0] sa, input logic [15:0] cn,
                       input logic fx, input logic rv, input int nbytes,
                       input int abort_at, input int first_wr, input string req);
        logic [15:0] o = sa;
        logic [1:0]  ix = 2'd0;
        int cyc = 0;
        int fw = -1;
        for (int k = 0; k < nbytes; k++) begin
            logic [23:0] fa;
            logic [7:0]  rb, dv;
            bit lp;
            fa = {bk, o};
            rb = m_breg(md, ix, br);
            lp = (rb == 8'h80) && m_wram(fa);
            if (!d) begin
                dv = m_aok(fa) ? mem_a(fa) : 8'h00;
                if (!lp) expq.push_back({1'b0, 16'h0, rb, dv});
            end else begin
                dv = lp ? 8'h00 : mem_b(rb);
                if (m_aok(fa)) expq.push_back({1'b1, fa, dv});
            end
            ix = ix + 2'd1;
            if (!fx) o = rv ? o - 16'd1 : o + 16'd1;
        end
        @(negedge clk);
        dir = d; mode = md; breg = br; bank = bk; src = sa; count = cn;
        fixed = fx; reverse = rv; en_wr = 1'b1; en_wdata = 1'b1;
        @(negedge clk);
        en_wr = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy_o, "R2", {req, " busy after start"}, busy_o, 1);
        while (busy_o) begin
            if (fw < 0 && (a_wr_o || b_wr_o)) fw = cyc;
            if (cyc == abort_at) begin en_wr = 1'b1; en_wdata = 1'b0; end
            else en_wr = 1'b0;
            cyc++;
            @(negedge clk);
        end
        en_wr = 1'b0;
        chk(cyc == 8 + 8 * nbytes, "R9", {req, " busy cycles"}, cyc, 8 + 8 * nbytes);
        chk(!en_o, "R10", {req, " enable cleared"}, en_o, 0);
        chk(expq.size() == 0, "R8", {req, " writes missing"}, expq.size(), 0);
        expq.delete();
        if (first_wr >= 0) chk(fw == first_wr, "R9", {req, " first write cycle"}, fw, first_wr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !en_o && !a_rd_o && !a_wr_o && !b_rd_o && !b_wr_o, "R1", "reset state",
            {busy_o, en_o, a_rd_o, a_wr_o, b_rd_o, b_wr_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: start with enable clear is ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 20; i++) begin
                if (busy_o || a_rd_o || b_rd_o || a_wr_o || b_wr_o) seen = 1'b1;
                @(negedge clk);
            end
            chk(!seen, "R2", "start ignored while disabled", seen, 0);
        end
        // R3, R6: every pattern code, wide to peripheral
        for (int m = 0; m < 8; m++)
            run(1'b0, 3'(m), 8'h18, 8'h01, 16'h8000, 16'd6, 1'b0, 1'b0, 6, -1,
                (m == 0) ? 12 : -1, "R3");
        // R6: peripheral to wide, code 4
        run(1'b1, 3'd4, 8'h10, 8'h7E, 16'h3000, 16'd5, 1'b0, 1'b0, 5, -1, -1, "R6");
        // R7: reverse, fixed, wrap of the offset
        run(1'b0, 3'd0, 8'h22, 8'h05, 16'h0001, 16'd4, 1'b0, 1'b1, 4, -1, -1, "R7");
        run(1'b1, 3'd1, 8'h22, 8'h05, 16'h9000, 16'd4, 1'b1, 1'b1, 4, -1, -1, "R7");
        run(1'b0, 3'd0, 8'h22, 8'hC3, 16'hFFFE, 16'd4, 1'b0, 1'b0, 4, -1, -1, "R7");
        // R4: blocked wide-side regions
        run(1'b0, 3'd0, 8'h18, 8'h00, 16'h421E, 16'd4, 1'b0, 1'b0, 4, -1, -1, "R4");
        run(1'b1, 3'd0, 8'h18, 8'h80, 16'h437E, 16'd4, 1'b0, 1'b0, 4, -1, -1, "R4");
        run(1'b0, 3'd0, 8'h18, 8'h3F, 16'h41FE, 16'd3, 1'b0, 1'b0, 3, -1, -1, "R4");
        run(1'b1, 3'd0, 8'h18, 8'h40, 16'h2100, 16'd2, 1'b0, 1'b0, 2, -1, -1, "R4");
        // R5: work-RAM loop through register 0x80
        run(1'b0, 3'd0, 8'h80, 8'h7F, 16'h0010, 16'd3, 1'b0, 1'b0, 3, -1, -1, "R5");
        run(1'b0, 3'd1, 8'h7F, 8'h00, 16'h1FFE, 16'd4, 1'b0, 1'b0, 4, -1, -1, "R5");
        run(1'b1, 3'd0, 8'h80, 8'h7E, 16'h0100, 16'd2, 1'b0, 1'b0, 2, -1, -1, "R5");
        // R8, R10: count 0 means a long burst; software clear stops it after byte 2
        run(1'b0, 3'd0, 8'h30, 8'h02, 16'h1234, 16'd0, 1'b0, 1'b0, 3, 26, 12, "R10");
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule